// File: doc/BRIEF.md
# Sampling Window Phase Selector

This block turns the outcome of a delay-line calibration sweep into one delay tap to program. Its input is a 64-bit pass/fail map in which bit i is set when delay step i passed; step 0 sits in the least significant bit. The block looks for the longest stretch of adjacent passing steps and returns a tap inside that stretch, together with the stretch's length. The tap sits in the middle of the stretch, except when the stretch begins at step 0. In that case the tap sits one third of the way in, so the choice leans toward the smallest delay.

The search is sequential. Each clock it measures the run of ones that begins at the current candidate position. It then jumps past that run, or moves by one step when there is no run. For a map whose upper half is empty, the search may end early once a long run close to step 0 has been seen. A one-cycle `start_i` pulse loads the map. A one-cycle `done_o` pulse marks results that stay valid until the next result is written. An empty map raises an error flag.

Top module: `win_phase_pick`

## Requirements
- R1: After reset `done_o`, `err_o`, `phase_o` and `run_len_o` are all zero.
- R2: `start_i` while idle loads `map_i` and begins a search. `start_i` during a search is ignored, and the result belongs to the map that was loaded.
- R3: `done_o` is high for exactly one cycle per search. `phase_o`, `run_len_o` and `err_o` change only in a cycle where `done_o` is high and otherwise hold their values.
- R4: A map of all zeros gives `err_o`=1, `phase_o`=0 and `run_len_o`=0. Any nonzero map gives `err_o`=0.
- R5: Bit i of `map_i` is delay step i, with step 0 in bit 0. Runs are counted upward from step 0 and end at bit 63. A run never joins bit 63 to bit 0.
- R6: Among runs of equal greatest length, the one at the lowest step is selected.
- R7: When bits 63..32 are all zero, the search ends as soon as a run of at least 12 has been measured and the best run so far begins below step 4. Runs beyond that point are not considered. When any of bits 63..32 is set, the search never ends early.
- R8: If the selected run begins at step 0, `phase_o` = (length / 3) mod 64, using truncating division.
- R9: If the selected run begins at step s > 0, `phase_o` = (s + length / 2) mod 64, using truncating division.
- R10: `run_len_o` gives the length of the selected run, from 1 to 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Loads the map and starts a search when idle |
| map_i | input | 64 | Pass/fail map, bit i = delay step i |
| done_o | output | 1 | One-cycle pulse when results are written |
| phase_o | output | 6 | Selected delay tap |
| run_len_o | output | 7 | Length of the selected run |
| err_o | output | 1 | Set when the loaded map had no passing step |

## Verification
Two functions can fall in the same cycle: the best-run update and the early-stop decision. The early-stop test reads the start position of the best run, and that position may be the one being written in that very cycle. The case is provoked by maps whose first long run begins at step 2, after two failing steps, and is followed by a longer run. The early stop can only fire if it uses the freshly updated start, so the tap must point into the first run (tap 8, length 12) and not into the later one. A second pairing is the same test with a single bit set in the upper half: the later run must then win.

// File: rtl/win_phase_pkg.sv
package win_phase_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;

endpackage

// File: rtl/win_run_meter.sv
// Counts the adjacent ones that begin at a candidate position of the map.
module win_run_meter #(
  parameter int MAP_W = 64,
  localparam int LW = $clog2(MAP_W + 1)
) (
  input  logic [MAP_W-1:0] map_i,
  input  logic [LW-1:0]    pos_i,
  output logic [LW-1:0]    len_o
);

  // Ones counted from bit 0 upward until the first zero.
  function automatic logic [LW-1:0] f_low_ones(input logic [MAP_W-1:0] v);
    logic [LW-1:0] n;
    logic          live;
    n    = '0;
    live = 1'b1;
    for (int i = 0; i < MAP_W; i++) begin
      if (live && v[i]) n = n + LW'(1);
      else              live = 1'b0;
    end
    return n;
  endfunction

  logic [MAP_W-1:0] aligned;

  // Zero fill from the top stops every run at the last bit: no wrap.
  assign aligned = map_i >> pos_i;
  assign len_o   = f_low_ones(aligned);

endmodule

// File: rtl/win_best_track.sv
// Holds the longest run seen so far; only a strictly longer run replaces it.
module win_best_track #(
  parameter int MAP_W = 64,
  localparam int PW = $clog2(MAP_W),
  localparam int LW = $clog2(MAP_W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic [PW-1:0] cand_start_i,
  input  logic [LW-1:0] cand_len_i,
  output logic [PW-1:0] best_start_nxt_o,
  output logic [LW-1:0] best_len_nxt_o
);

  logic [PW-1:0] best_start_q;
  logic [LW-1:0] best_len_q;
  logic          take;

  assign take = step_i && (cand_len_i > best_len_q);

  always_comb begin
    best_start_nxt_o = best_start_q;
    best_len_nxt_o   = best_len_q;
    if (clear_i) begin
      best_start_nxt_o = '0;
      best_len_nxt_o   = '0;
    end else if (take) begin
      best_start_nxt_o = cand_start_i;
      best_len_nxt_o   = cand_len_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_start_q <= '0;
      best_len_q   <= '0;
    end else begin
      best_start_q <= best_start_nxt_o;
      best_len_q   <= best_len_nxt_o;
    end
  end

  // R6: a run only as long as the stored best leaves the stored start alone.
  p_tie_keeps_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clear_i && cand_len_i == best_len_q) |=> $stable(best_start_q));

  // R6: the stored best never shrinks within a search.
  p_best_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> best_len_q >= $past(best_len_q));

  // R5: the stored run fits inside the map.
  p_best_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(best_start_q) + int'(best_len_q)) <= MAP_W);

endmodule

// File: rtl/win_phase_calc.sv
// Chooses a tap inside a run: one third in from step 0, centred otherwise.
module win_phase_calc #(
  parameter int MAP_W    = 64,
  parameter int LOW_DIV  = 3,
  parameter int MID_DIV  = 2,
  localparam int PW = $clog2(MAP_W),
  localparam int LW = $clog2(MAP_W + 1)
) (
  input  logic [PW-1:0] start_i,
  input  logic [LW-1:0] len_i,
  output logic [PW-1:0] tap_o
);

  function automatic logic [PW-1:0] f_tap(input logic [PW-1:0] s,
                                          input logic [LW-1:0] l);
    logic [LW:0] off;
    logic [LW:0] sum;
    if (s == '0) off = {1'b0, l / LW'(LOW_DIV)};
    else         off = {1'b0, l / LW'(MID_DIV)};
    sum = {{(LW + 1 - PW){1'b0}}, s} + off;
    return sum[PW-1:0];   // modulo the map width
  endfunction

  assign tap_o = f_tap(start_i, len_i);

endmodule

// File: rtl/win_phase_pick.sv
module win_phase_pick #(
  parameter int MAP_W       = 64,
  parameter int EARLY_LEN   = 12,
  parameter int EARLY_START = 4,
  localparam int PW   = $clog2(MAP_W),
  localparam int LW   = $clog2(MAP_W + 1),
  localparam int HALF = MAP_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [MAP_W-1:0] map_i,
  output logic             done_o,
  output logic [PW-1:0]    phase_o,
  output logic [LW-1:0]    run_len_o,
  output logic             err_o
);
  import win_phase_pkg::*;

  scan_state_e      st_q;
  logic [MAP_W-1:0] map_q;
  logic [LW-1:0]    pos_q;
  logic             done_q;
  logic [PW-1:0]    phase_q;
  logic [LW-1:0]    len_q;
  logic             err_q;

  // Named internal events
  logic             go;          // search accepted
  logic             map_zero;    // loaded map has no pass
  logic             step_en;     // one candidate position measured
  logic             upper_zero;  // upper half of the map empty
  logic             early_hit;   // early stop condition met
  logic             end_hit;     // next position past the last step
  logic             finish;      // results written this cycle
  logic [LW-1:0]    run_len;
  logic [LW-1:0]    adv;
  logic [LW-1:0]    pos_nxt;
  logic [PW-1:0]    best_start_nxt;
  logic [LW-1:0]    best_len_nxt;
  logic [PW-1:0]    tap;

  assign go         = (st_q == ST_IDLE) && start_i;
  assign map_zero   = (map_q == '0);
  assign step_en    = (st_q == ST_SCAN) && !map_zero;
  assign upper_zero = (map_q[MAP_W-1:HALF] == '0);

  win_run_meter #(.MAP_W(MAP_W)) meter_i (
    .map_i (map_q),
    .pos_i (pos_q),
    .len_o (run_len)
  );

  win_best_track #(.MAP_W(MAP_W)) track_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .clear_i          (go),
    .step_i           (step_en),
    .cand_start_i     (pos_q[PW-1:0]),
    .cand_len_i       (run_len),
    .best_start_nxt_o (best_start_nxt),
    .best_len_nxt_o   (best_len_nxt)
  );

  win_phase_calc #(.MAP_W(MAP_W)) calc_i (
    .start_i (best_start_nxt),
    .len_i   (best_len_nxt),
    .tap_o   (tap)
  );

  assign adv       = (run_len == '0) ? LW'(1) : run_len;
  assign pos_nxt   = pos_q + adv;
  assign end_hit   = (pos_nxt >= LW'(MAP_W));
  // The stop test reads the best start including this cycle's update.
  assign early_hit = upper_zero && (run_len >= LW'(EARLY_LEN))
                     && (best_start_nxt < PW'(EARLY_START));
  assign finish    = ((st_q == ST_SCAN) && map_zero)
                     || (step_en && (end_hit || early_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      map_q   <= '0;
      pos_q   <= '0;
      done_q  <= 1'b0;
      phase_q <= '0;
      len_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      done_q <= finish;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q  <= ST_SCAN;
            map_q <= map_i;
            pos_q <= '0;
          end
        end
        ST_SCAN: begin
          pos_q <= pos_nxt;
          if (finish) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
      if (finish) begin
        phase_q <= map_zero ? '0 : tap;
        len_q   <= map_zero ? '0 : best_len_nxt;
        err_q   <= map_zero;
      end
    end
  end

  assign done_o    = done_q;
  assign phase_o   = phase_q;
  assign run_len_o = len_q;
  assign err_o     = err_q;

  // R3: completion lasts a single cycle.
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3: results hold between completions.
  p_result_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(phase_o) && $stable(run_len_o) && $stable(err_o)));

  // R4: an error result carries a zero tap and zero length.
  p_err_zeroes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (phase_o == '0 && run_len_o == '0));

  // R10: a good result always carries a nonempty run.
  p_len_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (run_len_o != '0));

  // R5: the search position only moves forward.
  p_pos_forward_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !finish) |=> (pos_q > $past(pos_q)));

  // R2: the loaded map is frozen while a search runs.
  p_map_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SCAN) |=> $stable(map_q));

endmodule

// File: tb/win_phase_pick_tb_top.sv
module win_phase_pick_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WAIT_LIMIT = 200;
  localparam int WDOG_LIMIT = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] map_i = '0;
  logic        done_o;
  logic [5:0]  phase_o;
  logic [6:0]  run_len_o;
  logic        err_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  win_phase_pick dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .map_i     (map_i),
    .done_o    (done_o),
    .phase_o   (phase_o),
    .run_len_o (run_len_o),
    .err_o     (err_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WDOG_LIMIT) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not end, actual=%0d expected<%0d", cycles, WDOG_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Independent model: walk the bits once, closing each run at a zero or the top.
  task automatic model(input logic [63:0] m, output int ph, output int ln, output bit er);
    int  bs, bl, cs, cl;
    bit  up0;
    bs = 0; bl = 0; cs = 0; cl = 0;
    up0 = (m[63:32] == 32'h0);
    er  = (m == 64'h0);
    for (int i = 0; i <= 64; i++) begin
      if (i < 64 && m[i]) begin
        if (cl == 0) cs = i;
        cl++;
      end else begin
        if (cl > bl) begin bl = cl; bs = cs; end
        if (up0 && cl >= 12 && bs < 4) break;
        cl = 0;
      end
    end
    ln = er ? 0 : bl;
    if (er)           ph = 0;
    else if (bs == 0) ph = (bl / 3) % 64;
    else              ph = (bs + bl / 2) % 64;
  endtask

  // Launch one search and wait for its completion; checks the pulse width.
  task automatic run_map(input string req, input logic [63:0] m, output bit seen);
    seen = 1'b0;
    @(negedge clk);
    start_i = 1'b1;
    map_i   = m;
    @(negedge clk);
    start_i = 1'b0;
    map_i   = ~m;
    for (int k = 0; k < WAIT_LIMIT; k++) begin
      @(negedge clk);
      if (done_o) begin seen = 1'b1; break; end
    end
    check(req, "done seen", seen, 1);
  endtask

  task automatic t_map(input string req, input logic [63:0] m,
                       input int eph, input int eln, input bit eer);
    bit seen;
    run_map(req, m, seen);
    if (seen) begin
      check(req, "phase", phase_o, eph);
      check(req, "run length", run_len_o, eln);
      check(req, "error flag", err_o, eer);
      @(negedge clk);
      check("R3", "done drops after one cycle", done_o, 0);
    end
  endtask

  task automatic t_model(input string req, input logic [63:0] m);
    int ph, ln; bit er;
    model(m, ph, ln, er);
    t_map(req, m, ph, ln, er);
  endtask

  task automatic t_reset();
    check("R1", "done after reset", done_o, 0);
    check("R1", "err after reset", err_o, 0);
    check("R1", "phase after reset", phase_o, 0);
    check("R1", "length after reset", run_len_o, 0);
  endtask

  task automatic t_examples();
    t_map("R8", 64'h0000_0000_0ffc_07ff, 3, 11, 0);   // R8 R10
    t_map("R9", 64'hffff_ffff_fffc_07ff, 41, 46, 0);  // R9 R10
    t_map("R8", 64'hffff_ffff_ffff_ffff, 21, 64, 0);  // whole map passes
  endtask

  task automatic t_zero();
    t_map("R4", 64'h0, 0, 0, 1);
    t_map("R4", 64'h0000_0000_0000_0010, 4, 1, 0);    // err clears
  endtask

  task automatic t_tie();
    t_map("R6", 64'h0000_0000_0000_07df, 1, 5, 0);
    t_map("R6", 64'h0000_0000_0000_0e1c, 3, 3, 0);
  endtask

  task automatic t_early();
    t_map("R7", 64'h0000_0000_ffff_efff, 4, 12, 0);  // stops at first run
    t_map("R7", 64'h0000_0000_ffff_bffc, 8, 12, 0);  // run at step 2 triggers stop
    t_map("R7", 64'h0000_0001_ffff_efff, 23, 20, 0); // upper bit set: no stop
  endtask

  task automatic t_edges();
    t_map("R5", 64'h8000_0000_0000_0000, 63, 1, 0);  // run ends at the top bit
    t_map("R5", 64'hf000_0000_0000_0007, 62, 4, 0);  // no joining across the top
    t_map("R9", 64'h0000_0000_0000_0ffe, 6, 11, 0);
  endtask

  task automatic t_sweep();
    t_model("R5", 64'h0123_4567_89ab_cdef);
    t_model("R5", 64'h00ff_00ff_f0f0_0f0f);
    t_model("R5", 64'hffff_0000_0000_ffff);
    t_model("R5", 64'h0000_0fff_ffff_f000);
    t_model("R7", 64'h0000_0000_7fff_fff8);
  endtask

  task automatic t_busy_start();
    int pulses;
    int ph_first;
    pulses = 0;
    ph_first = -1;
    @(negedge clk);
    start_i = 1'b1;
    map_i   = 64'h8000_0000_0000_0000;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      if (k == 4) begin start_i = 1'b1; map_i = 64'hffff_ffff_ffff_ffff; end
      if (k == 5) start_i = 1'b0;
      if (done_o) begin
        pulses++;
        if (ph_first < 0) ph_first = phase_o;
      end
    end
    check("R2", "phase of first map despite busy start", ph_first, 63);
    check("R3", "completions for one accepted start", pulses, 1);
  endtask

  task automatic t_hold();
    logic [5:0] ph;
    logic [6:0] ln;
    bit seen;
    run_map("R3", 64'h0000_0000_00ff_0000, seen);
    ph = phase_o;
    ln = run_len_o;
    for (int k = 0; k < 10; k++) @(negedge clk);
    check("R3", "phase held", phase_o, ph);
    check("R3", "length held", run_len_o, ln);
    check("R9", "centre of mid run", ph, 20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_examples();
    t_zero();
    t_tie();
    t_early();
    t_edges();
    t_sweep();
    t_busy_start();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule